// File: doc/BRIEF.md
# SDRAM Device-Side Read Latency and Byte-Mask Path

This block is the data-pin stage of a synchronous DRAM device model. Each read word that the array supplies is held back by a programmable number of clock cycles, from one to three, before it appears on a 16-bit output bus. For each byte lane there is an output enable, which a byte mask can drop. A mask bit on the read side takes effect with a fixed lag of two cycles, however the latency is set.

On the write side, bus data and a per-byte write enable go straight to the array in the cycle of the write. A mask bit there suppresses the write of that lane at once. A precharge that arrives together with a read strobe discards that strobe, and the bus then drains to idle. The command decoder, the storage array and the electrical drive all sit outside this block.

Top module: `sdr_dq_path`

## Requirements
- R1: A read strobe (`rd_vld_i`=1, `prech_i`=0) sampled at rising edge t, with effective latency L, puts its word on `dq_o` and raises the lane enables during the cycle after edge t+L-1, for exactly one cycle. L is 1, 2 or 3.
- R2: `lat_i` is sampled at every edge and picks the latency of the word shown after that edge. Code 0 acts as latency 1. The code may change only while no read is in flight.
- R3: `dqm_i[b]` sampled at edge t forces `dq_oe_o[b]` low during the cycle after edge t+1, whatever the command and the latency. Bit 0 governs lane [7:0] and bit 1 governs lane [15:8].
- R4: `arr_wr_be_o[b]` equals `wr_en_i` AND NOT `dqm_i[b]` in the same cycle, with no register in the path.
- R5: `arr_wr_data_o` carries `wr_data_i` unchanged in the same cycle.
- R6: A precharge sampled at the same edge as a read strobe discards that strobe. Words from earlier strobes still appear, so with no later strobes the bus is idle from edge t+L-1 after a precharge at edge t.
- R7: Any lane whose enable is low reads as zero on `dq_o`.
- R8: While `rst_n` is low at an edge, every enable and every `dq_o` bit is zero after that edge. A read sampled at or before a reset edge never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_vld_i | input | 1 | Read word from the array is valid this cycle |
| rd_data_i | input | 16 | Read word from the array |
| prech_i | input | 1 | Precharge command this cycle |
| wr_en_i | input | 1 | Write command this cycle |
| wr_data_i | input | 16 | Write data from the bus |
| dqm_i | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| lat_i | input | 2 | Read latency code (0 or 1 = one cycle, 2, 3) |
| dq_o | output | 16 | Delayed read data, masked lanes zero |
| dq_oe_o | output | 2 | Per-lane output enable |
| arr_wr_data_o | output | 16 | Write data to the array |
| arr_wr_be_o | output | 2 | Per-lane write enable to the array |

## Verification
One mask input serves two purposes in the same cycle. It gates the write being issued now, and it also gates the read lanes that leave two edges later. The stimulus puts masked writes right next to reads at latency two, so that a mask pattern blocks a write lane in its own cycle and later shuts the matching lane of a read word. The bench judges both effects at the ports in the cycles where each one is due: the write enables straight after the inputs are driven, and the lane enables and data after the relevant edges.

// File: rtl/sdr_dq_pkg.sv
// Package for the SDRAM data-pin path.
// Holds the default geometry and turns a raw latency code into the
// latency it stands for. Assumes latency codes are small unsigned values.
package sdr_dq_pkg;

    localparam int unsigned DEF_DATA_W  = 16;
    localparam int unsigned DEF_BYTE_W  = 8;
    localparam int unsigned DEF_MAX_LAT = 3;
    localparam int unsigned DEF_MSK_LAG = 2;

    // Maps a latency code to its latency: 0 means one cycle, codes above the max saturate.
    function automatic int unsigned eff_lat(input int unsigned code, input int unsigned max_lat);
        if (code == 0)
            return 1;
        if (code > max_lat)
            return max_lat;
        return code;
    endfunction

endpackage

// File: rtl/sdr_lat_hold.sv
// Latency code register.
// Samples the raw latency code at every edge and holds it in normalised
// form (1..MAX_LAT) for the output selector. Assumes the code changes
// only when nothing is in flight. Reset value is latency 1.
module sdr_lat_hold
    import sdr_dq_pkg::*;
#(
    parameter int unsigned MAX_LAT = DEF_MAX_LAT,
    parameter int unsigned LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] lat_code_i,
    output logic [LAT_W-1:0] lat_o
);

    logic [LAT_W-1:0] lat_q;

    // Normalise the code and register it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= LAT_W'(1);
        else
            lat_q <= LAT_W'(eff_lat(32'(lat_code_i), MAX_LAT));
    end

    assign lat_o = lat_q;

    // R2: code zero must select latency one on the next cycle
    a_r2_zero_code_is_one: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_code_i == '0) |=> (lat_o == LAT_W'(1)))
        else $error("a_r2_zero_code_is_one");

endmodule

// File: rtl/sdr_rd_delay.sv
// Read word delay line.
// A chain of MAX_LAT register stages carries a valid flag and a data
// word. Stage 0 takes the array word at each edge. A precharge in the
// same cycle strips the valid flag. The output selector picks the stage
// that matches the held latency. Assumes lat_sel_i is within 1..MAX_LAT.
module sdr_rd_delay #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned MAX_LAT = 3,
    parameter int unsigned LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld_i,
    input  logic              in_kill_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic [LAT_W-1:0]  lat_sel_i,
    output logic              out_vld_o,
    output logic [DATA_W-1:0] out_data_o
);

    logic [MAX_LAT-1:0]             stg_vld;
    logic [MAX_LAT-1:0][DATA_W-1:0] stg_dat;

    // Shift the valid flags and words one stage per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld <= '0;
            stg_dat <= '0;
        end else begin
            stg_vld[0] <= in_vld_i & ~in_kill_i;
            stg_dat[0] <= in_data_i;
            for (int k = 1; k < int'(MAX_LAT); k++) begin
                stg_vld[k] <= stg_vld[k-1];
                stg_dat[k] <= stg_dat[k-1];
            end
        end
    end

    // Pick the stage that matches the held latency.
    always_comb begin
        out_vld_o  = stg_vld[0];
        out_data_o = stg_dat[0];
        for (int k = 1; k < int'(MAX_LAT); k++) begin
            if (lat_sel_i == LAT_W'(k + 1)) begin
                out_vld_o  = stg_vld[k];
                out_data_o = stg_dat[k];
            end
        end
    end

    // R6: a strobe that meets a precharge never enters the chain
    a_r6_prech_drops_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && in_kill_i) |=> !stg_vld[0])
        else $error("a_r6_prech_drops_strobe");

endmodule

// File: rtl/sdr_mask_lag.sv
// Read-side byte mask lag.
// Delays the byte mask by LAG register stages so that it lines up with
// the lane enables. The mask is shifted every cycle, whether the
// command is a read, a write or nothing. Assumes LAG >= 1.
module sdr_mask_lag #(
    parameter int unsigned NBYTES = 2,
    parameter int unsigned LAG    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] dqm_i,
    output logic [NBYTES-1:0] dqm_late_o
);

    logic [LAG-1:0][NBYTES-1:0] pipe;

    // Shift the mask through the lag stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= dqm_i;
            for (int k = 1; k < int'(LAG); k++)
                pipe[k] <= pipe[k-1];
        end
    end

    assign dqm_late_o = pipe[LAG-1];

endmodule

// File: rtl/sdr_wr_gate.sv
// Write lane gate.
// Passes bus data to the array and builds the per-lane write enable
// from the write command and the current byte mask. This path is purely
// combinational: a write and its mask act in the cycle they appear.
module sdr_wr_gate #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NBYTES = 2
) (
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [NBYTES-1:0] dqm_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [NBYTES-1:0] wr_be_o
);

    genvar b;
    generate
        for (b = 0; b < int'(NBYTES); b++) begin : g_be
            // Lane write enable: the command is present and the lane is not masked.
            assign wr_be_o[b] = wr_en_i & ~dqm_i[b];
        end
    endgenerate

    assign wr_data_o = wr_data_i;

endmodule

// File: rtl/sdr_dq_path.sv
// SDRAM data-pin path, top level.
// Delays read words by a programmable latency, applies the read-side
// byte mask two cycles after it is sampled, zeroes lanes that are off,
// and gates writes to the array with the current-cycle mask.
// Assumes the latency code is changed only while no read is in flight.
module sdr_dq_path
    import sdr_dq_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned BYTE_W   = DEF_BYTE_W,
    parameter int unsigned MAX_LAT  = DEF_MAX_LAT,
    parameter int unsigned MASK_LAG = DEF_MSK_LAG,
    localparam int unsigned NBYTES  = DATA_W / BYTE_W,
    localparam int unsigned LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vld_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              prech_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [NBYTES-1:0] dqm_i,
    input  logic [LAT_W-1:0]  lat_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [NBYTES-1:0] dq_oe_o,
    output logic [DATA_W-1:0] arr_wr_data_o,
    output logic [NBYTES-1:0] arr_wr_be_o
);

    logic [LAT_W-1:0]  lat_q;
    logic              sel_vld;
    logic [DATA_W-1:0] sel_data;
    logic [NBYTES-1:0] mask_late;

    sdr_lat_hold #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .lat_code_i (lat_i),
        .lat_o      (lat_q)
    );

    sdr_rd_delay #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld_i   (rd_vld_i),
        .in_kill_i  (prech_i),
        .in_data_i  (rd_data_i),
        .lat_sel_i  (lat_q),
        .out_vld_o  (sel_vld),
        .out_data_o (sel_data)
    );

    sdr_mask_lag #(.NBYTES(NBYTES), .LAG(MASK_LAG)) u_msk (
        .clk        (clk),
        .rst_n      (rst_n),
        .dqm_i      (dqm_i),
        .dqm_late_o (mask_late)
    );

    sdr_wr_gate #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_wr (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .dqm_i     (dqm_i),
        .wr_data_o (arr_wr_data_o),
        .wr_be_o   (arr_wr_be_o)
    );

    genvar b;
    generate
        for (b = 0; b < int'(NBYTES); b++) begin : g_lane
            // Lane enable: a delayed word is present and the lagged mask is clear.
            assign dq_oe_o[b] = sel_vld & ~mask_late[b];
            // Lane data: the word byte when enabled, zero otherwise.
            assign dq_o[b*BYTE_W +: BYTE_W] = dq_oe_o[b] ? sel_data[b*BYTE_W +: BYTE_W] : '0;

            // R4: a lane write enable needs a write and a clear mask this cycle
            a_r4_wr_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
                arr_wr_be_o[b] |-> (wr_en_i && !dqm_i[b]))
                else $error("a_r4_wr_lane_gate");

            if (MASK_LAG == 2) begin : g_lag2
                // R3: a sampled mask bit shuts its lane two cycles on
                a_r3_mask_two_late: assert property (@(posedge clk) disable iff (!rst_n)
                    dqm_i[b] |-> ##2 !dq_oe_o[b])
                    else $error("a_r3_mask_two_late");
            end
        end
    endgenerate

    // R1: at latency one an accepted strobe is selected on the next cycle
    a_r1_lat1_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_i && !prech_i && lat_i == LAT_W'(1)) |=> sel_vld)
        else $error("a_r1_lat1_next_cycle");

endmodule

// File: tb/tb_sdr_dq_path.sv
// Self-checking bench: a stimulus table walked by one loop, with expected
// port values computed from the requirements, then directed reset tests.
module tb_sdr_dq_path;

    logic        clk;
    logic        rst_n;
    logic        rd_vld_i;
    logic [15:0] rd_data_i;
    logic        prech_i;
    logic        wr_en_i;
    logic [15:0] wr_data_i;
    logic [1:0]  dqm_i;
    logic [1:0]  lat_i;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe_o;
    logic [15:0] arr_wr_data_o;
    logic [1:0]  arr_wr_be_o;

    int n_chk  = 0;
    int n_fail = 0;
    int k      = 0;

    bit          h_ok  [0:1023];
    bit          h_rd  [0:1023];
    bit          h_pre [0:1023];
    logic [15:0] h_dat [0:1023];
    logic [1:0]  h_dqm [0:1023];
    logic [1:0]  h_lat [0:1023];

    sdr_dq_path dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_vld_i      (rd_vld_i),
        .rd_data_i     (rd_data_i),
        .prech_i       (prech_i),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .dqm_i         (dqm_i),
        .lat_i         (lat_i),
        .dq_o          (dq_o),
        .dq_oe_o       (dq_oe_o),
        .arr_wr_data_o (arr_wr_data_o),
        .arr_wr_be_o   (arr_wr_be_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Fields: [38] read, [37] precharge, [36] write, [35:34] mask,
    // [33:32] latency code, [31:16] read word, [15:0] write word.
    localparam int NV = 31;
    localparam logic [38:0] TBL [0:NV-1] = '{
        {3'b100, 2'b00, 2'd1, 16'h1111, 16'h0000}, // R1 latency one burst
        {3'b100, 2'b00, 2'd1, 16'h2222, 16'h0000},
        {3'b100, 2'b01, 2'd1, 16'h3333, 16'h0000}, // R3 low lane shut two later
        {3'b100, 2'b00, 2'd1, 16'h4444, 16'h0000},
        {3'b100, 2'b10, 2'd1, 16'h5555, 16'h0000}, // R3 high lane
        {3'b000, 2'b00, 2'd1, 16'h0000, 16'h0000},
        {3'b000, 2'b00, 2'd1, 16'h0000, 16'h0000},
        {3'b100, 2'b00, 2'd2, 16'hA001, 16'h0000}, // R1 latency two
        {3'b101, 2'b11, 2'd2, 16'hA002, 16'hBEEF}, // R4 write masked with read
        {3'b101, 2'b01, 2'd2, 16'hA003, 16'hCAFE}, // R4 R5 partial write
        {3'b000, 2'b00, 2'd2, 16'h0000, 16'h0000},
        {3'b000, 2'b00, 2'd2, 16'h0000, 16'h0000},
        {3'b000, 2'b00, 2'd2, 16'h0000, 16'h0000},
        {3'b100, 2'b00, 2'd3, 16'hB001, 16'h0000}, // R1 latency three
        {3'b100, 2'b00, 2'd3, 16'hB002, 16'h0000},
        {3'b110, 2'b00, 2'd3, 16'hB003, 16'h0000}, // R6 precharge drops strobe
        {3'b000, 2'b00, 2'd3, 16'h0000, 16'h0000},
        {3'b000, 2'b10, 2'd3, 16'h0000, 16'h0000}, // R3 mask independent of latency
        {3'b000, 2'b00, 2'd3, 16'h0000, 16'h0000},
        {3'b000, 2'b00, 2'd3, 16'h0000, 16'h0000},
        {3'b100, 2'b00, 2'd0, 16'hC001, 16'h0000}, // R2 code zero acts as one
        {3'b100, 2'b01, 2'd0, 16'hC002, 16'h0000},
        {3'b110, 2'b00, 2'd0, 16'hC003, 16'h0000}, // R6 at latency one
        {3'b001, 2'b10, 2'd0, 16'h0000, 16'h1234}, // R4 R7
        {3'b000, 2'b00, 2'd0, 16'h0000, 16'h0000},
        {3'b001, 2'b00, 2'd1, 16'h0000, 16'h5A5A}, // R5 plain write
        {3'b001, 2'b11, 2'd1, 16'h0000, 16'hFFFF}, // R4 fully masked write
        {3'b101, 2'b10, 2'd1, 16'hD001, 16'h0F0F},
        {3'b110, 2'b00, 2'd1, 16'hD002, 16'h0000},
        {3'b000, 2'b00, 2'd1, 16'h0000, 16'h0000},
        {3'b000, 2'b00, 2'd1, 16'h0000, 16'h0000}
    };

    // Compare one value and report a mismatch.
    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, k);
        end
    endtask

    // Expected lane enables and bus value after edge n, from the requirements.
    task automatic expect_at(input int n, output logic [1:0] oe, output logic [15:0] d);
        int   lat;
        int   src;
        bit   valid;
        logic [1:0] mask;
        oe = 2'b00;
        d  = 16'h0000;
        if (n < 0 || !h_ok[n])
            return;
        lat   = (h_lat[n] == 2'd0) ? 1 : int'(h_lat[n]);
        src   = n - lat + 1;
        valid = 1'b0;
        if (src >= 0) begin
            valid = h_rd[src] && !h_pre[src];
            for (int j = src; j <= n; j++)
                if (!h_ok[j]) valid = 1'b0;
        end
        mask = (n >= 1 && h_ok[n-1]) ? h_dqm[n-1] : 2'b00;
        oe   = {valid, valid} & ~mask;
        if (src >= 0) begin
            d[7:0]  = oe[0] ? h_dat[src][7:0]  : 8'h00;
            d[15:8] = oe[1] ? h_dat[src][15:8] : 8'h00;
        end
    endtask

    // One cycle: drive at the falling edge, check writes, clock, check reads.
    task automatic step(input bit rd, input bit pre, input bit wr, input logic [1:0] m,
                        input logic [1:0] lt, input logic [15:0] rdd, input logic [15:0] wrd);
        logic [1:0]  e_oe;
        logic [15:0] e_d;
        rd_vld_i  = rd;
        prech_i   = pre;
        wr_en_i   = wr;
        dqm_i     = m;
        lat_i     = lt;
        rd_data_i = rdd;
        wr_data_i = wrd;
        #1;
        check("R4 write lane enables", {14'd0, arr_wr_be_o}, {14'd0, (wr ? ~m : 2'b00)});
        check("R5 write data", arr_wr_data_o, wrd);
        @(posedge clk);
        h_ok[k]  = rst_n;
        h_rd[k]  = rd;
        h_pre[k] = pre;
        h_dat[k] = rdd;
        h_dqm[k] = m;
        h_lat[k] = lt;
        k++;
        @(negedge clk);
        expect_at(k - 1, e_oe, e_d);
        if (!h_ok[k-1]) begin
            check("R8 enables under reset", {14'd0, dq_oe_o}, 16'h0000);
            check("R8 bus under reset", dq_o, 16'h0000);
        end else begin
            check("R1 R3 R6 lane enables", {14'd0, dq_oe_o}, {14'd0, e_oe});
            check("R1 R7 bus value", dq_o, e_d);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (3000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rd_vld_i = 1'b0; prech_i = 1'b0; wr_en_i = 1'b0;
        dqm_i = 2'b00; lat_i = 2'd1; rd_data_i = '0; wr_data_i = '0;
        @(negedge clk);
        // R8: reset state, with a read strobe that must never show
        step(1'b1, 1'b0, 1'b0, 2'b00, 2'd1, 16'hDEAD, 16'h0000);
        step(1'b0, 1'b0, 1'b0, 2'b00, 2'd1, 16'h0000, 16'h0000);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            step(TBL[i][38], TBL[i][37], TBL[i][36], TBL[i][35:34], TBL[i][33:32],
                 TBL[i][31:16], TBL[i][15:0]);
        // R8: reset lands while latency-three reads are in flight
        step(1'b0, 1'b0, 1'b0, 2'b00, 2'd3, 16'h0000, 16'h0000);
        step(1'b0, 1'b0, 1'b0, 2'b00, 2'd3, 16'h0000, 16'h0000);
        step(1'b1, 1'b0, 1'b0, 2'b00, 2'd3, 16'hE001, 16'h0000);
        step(1'b1, 1'b0, 1'b0, 2'b00, 2'd3, 16'hE002, 16'h0000);
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 2'b00, 2'd3, 16'h0000, 16'h0000);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++)
            step(1'b0, 1'b0, 1'b0, 2'b00, 2'd3, 16'h0000, 16'h0000);
        // R1 R2: after reset the path works again at latency three
        step(1'b1, 1'b0, 1'b0, 2'b00, 2'd3, 16'hF00D, 16'h0000);
        for (int i = 0; i < 4; i++)
            step(1'b0, 1'b0, 1'b0, 2'b00, 2'd3, 16'h0000, 16'h0000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule